// File: doc/BRIEF.md
# Frequency Synthesizer Serial Programming Controller

This block sits on the host side of a frequency synthesizer and loads its six 32-bit configuration registers. It uses a three-wire serial link: a serial clock, a data line and a latch enable. It also drives the synthesizer's chip-enable line and watches its lock-detect output. The contents of the six registers arrive on a parallel input bus. Slot k sits at `cfg_words[32k+31:32k]`.

Once power is enabled, the controller raises chip enable. It then writes the six slots from the highest index down to slot 0 and starts polling lock detect. From then on a host can rewrite any single slot through a valid/ready request port. Status outputs report whether a request can be taken, when a word has been committed, and whether lock was reached or timed out. The serial clock is derived from the system clock. `CLKDIV` sets the number of system cycles in each half of a serial clock period, and it must be at least 2.

Top module: `synth_prog_ctrl`

## Requirements
- R1: Each word is sent inside one window in which `ser_le` is low. The window contains exactly 32 rising edges of `ser_clk`. Bit 31 of the slot is sent first and bit 0 last, so the bits captured on the rising edges, in order, equal the slot value.
- R2: `ser_clk` is low whenever `ser_le` is high. `ser_data` does not change while `ser_clk` stays high.
- R3: Each low and each high phase of `ser_clk` inside a window lasts exactly `CLKDIV` cycles. This includes the low phase that runs from the fall of `ser_le` to the first rising edge, and the low phase that runs from the last falling edge to the rise of `ser_le`. Between two words that follow one another, `ser_le` stays high for at least `4*CLKDIV` cycles.
- R4: During reset, `ser_le` is high and `ser_clk`, `chip_en`, `req_ready`, `locked` and `done` are low. `chip_en` is high before `ser_le` first falls. After power-up the slots are written in the order 5, 4, 3, 2, 1, 0.
- R5: `req_ready` stays low until the sixth power-up word has been committed. A request with `req_sel` from 0 to 5 is accepted on a cycle where `req_valid` and `req_ready` are both high. It sends slot `req_sel` and raises `busy` on the next cycle. `busy` is high whenever `ser_le` is low.
- R6: A request accepted with `req_sel` equal to 6 or 7 is dropped. No window opens, `done` stays low, and `req_ready` is high again on the next cycle.
- R7: `done` is high for exactly one cycle for each committed word. That cycle is the first cycle in which `ser_le` is high after a complete window.
- R8: `chip_en` follows `pwr_en` with one cycle of delay. When `pwr_en` falls, then on the next cycle `locked` and `lock_fail` are low, `ser_le` is high and `ser_clk` is low, and any word in flight is abandoned without `done`. When `pwr_en` returns, the six-word power-up sequence runs again.
- R9: `lock_det` passes through a two-flop synchronizer. The synchronized value is sampled once per cycle from the cycle after the sixth power-up `done`. `locked` rises when the synchronized value has been high for N consecutive samples, where N is `lock_polls`, or 1 when `lock_polls` is 0.
- R10: If `LOCK_TMO` samples pass without lock, `lock_fail` rises. `locked` and `lock_fail` are never high together. Each stays high until `pwr_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Power enable for the synthesizer; low forces power-down |
| cfg_words | input | NREG*WORD_W | Register contents, slot k at bits 32k+31:32k |
| req_valid | input | 1 | Single-slot rewrite request |
| req_sel | input | SEL_W | Slot index of the request |
| req_ready | output | 1 | Request can be taken this cycle |
| busy | output | 1 | Sequence or word transfer in progress |
| done | output | 1 | One-cycle pulse per committed word |
| lock_polls | input | POLL_W | Consecutive high samples needed for lock |
| locked | output | 1 | Lock confirmed |
| lock_fail | output | 1 | Lock not reached within the timeout |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_data | output | 1 | Serial data, MSB first |
| ser_le | output | 1 | Latch enable; its rise commits a word |
| chip_en | output | 1 | Synthesizer chip enable |
| lock_det | input | 1 | Asynchronous lock-detect input |

## Verification
The hardest situation to reach is a power-down that lands in the middle of a window. It must cut the word short with no commit and then restart the whole six-word sequence. The stimulus waits for an accepted rewrite to open its window, lets several bits go out, and then drops `pwr_en`. The bench's model discards its queue of expected words at that instant and rebuilds it when chip enable returns.

Lock qualification is driven by a lock-detect pattern made of runs four samples long, so a threshold of three is reached only inside a run. A threshold of zero and a lock-detect held low are then used to reach the immediate-lock case and the timeout case.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  typedef enum logic [1:0] {
    SQ_OFF,
    SQ_INIT,
    SQ_IDLE,
    SQ_UPD
  } seq_st_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SHIFT,
    TX_HOLD,
    TX_GAP
  } tx_st_t;

  // cycles that latch enable stays high after a commit, in half periods
  localparam int unsigned GAP_HALVES = 4;

  function automatic int unsigned gap_cycles(input int unsigned half_len);
    return GAP_HALVES * half_len;
  endfunction

endpackage

// File: rtl/synth_frame_tx.sv
module synth_frame_tx
  import synth_prog_pkg::*;
#(
  parameter int unsigned CLKDIV = 2,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              sdata,
  output logic              le
);
  localparam int unsigned GAPN = gap_cycles(CLKDIV);
  localparam int unsigned CW   = $clog2(GAPN + 1);
  localparam int unsigned BW   = $clog2(WORD_W);

  tx_st_t            st;
  logic [CW-1:0]     cnt;
  logic              ph;
  logic [BW-1:0]     bi;
  logic [WORD_W-1:0] sh;
  logic              done_q;

  // named internal events
  wire half_end = (cnt == CW'(CLKDIV - 1));
  wire gap_end  = (cnt == CW'(GAPN - 1));
  wire last_bit = (bi == BW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TX_IDLE; cnt <= '0; ph <= 1'b0; bi <= '0; sh <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        st <= TX_IDLE; cnt <= '0; ph <= 1'b0; bi <= '0;
      end else begin
        case (st)
          TX_IDLE: if (start) begin
            st <= TX_SHIFT; sh <= word; cnt <= '0; ph <= 1'b0; bi <= '0;
          end
          TX_SHIFT: if (half_end) begin
            cnt <= '0;
            if (!ph) ph <= 1'b1;
            else begin
              ph <= 1'b0;
              if (last_bit) st <= TX_HOLD;
              else begin
                bi <= bi + 1'b1;
                sh <= {sh[WORD_W-2:0], 1'b0};
              end
            end
          end else cnt <= cnt + 1'b1;
          TX_HOLD: if (half_end) begin
            cnt <= '0; st <= TX_GAP; done_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
          default: if (gap_end) begin
            cnt <= '0; st <= TX_IDLE;
          end else cnt <= cnt + 1'b1;
        endcase
      end
    end
  end

  assign sclk  = (st == TX_SHIFT) && ph;
  assign le    = (st == TX_IDLE) || (st == TX_GAP);
  assign sdata = sh[WORD_W-1];
  assign busy  = (st != TX_IDLE);
  assign done  = done_q;

  // checker state: rising serial edges inside the current window
  logic          sclk_d;
  logic [BW:0]   rises;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0; rises <= '0;
    end else begin
      sclk_d <= sclk;
      if (le) rises <= '0;
      else if (sclk && !sclk_d) rises <= rises + 1'b1;
    end
  end

  // R2
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n) le |-> !sclk);
  // R2
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));
  // R1
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rises == (BW+1)'(WORD_W)));
  // R3
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX_SHIFT && !half_end && !abort) |=> $stable(sclk));

endmodule

// File: rtl/synth_lock_mon.sv
module synth_lock_mon #(
  parameter int unsigned POLL_W   = 8,
  parameter int unsigned LOCK_TMO = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic              go,
  input  logic              lock_det,
  input  logic [POLL_W-1:0] lock_polls,
  output logic              locked,
  output logic              lock_fail
);
  localparam int unsigned TW = $clog2(LOCK_TMO + 1);

  function automatic logic [POLL_W:0] need_of(input logic [POLL_W-1:0] p);
    return (p == '0) ? (POLL_W+1)'(1) : {1'b0, p};
  endfunction

  logic            ld_s1, ld_s, polling, locked_q, fail_q;
  logic [POLL_W:0] run;
  logic [TW-1:0]   tmo;

  wire hit    = polling && ld_s && ((run + 1'b1) >= need_of(lock_polls));
  wire expire = polling && !hit && (tmo == TW'(LOCK_TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_s1 <= 1'b0; ld_s <= 1'b0;
    end else begin
      ld_s1 <= lock_det; ld_s <= ld_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      polling <= 1'b0; run <= '0; tmo <= '0; locked_q <= 1'b0; fail_q <= 1'b0;
    end else if (!pwr_en) begin
      polling <= 1'b0; run <= '0; tmo <= '0; locked_q <= 1'b0; fail_q <= 1'b0;
    end else if (go) begin
      polling <= 1'b1; run <= '0; tmo <= '0; locked_q <= 1'b0; fail_q <= 1'b0;
    end else if (polling) begin
      if (hit) begin
        locked_q <= 1'b1; polling <= 1'b0;
      end else begin
        run <= ld_s ? run + 1'b1 : '0;
        tmo <= tmo + 1'b1;
        if (expire) begin
          fail_q <= 1'b1; polling <= 1'b0;
        end
      end
    end
  end

  assign locked    = locked_q;
  assign lock_fail = fail_q;

  // R10
  excl_status_chk: assert property (@(posedge clk) disable iff (!rst_n) !(locked && lock_fail));
  // R8
  pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> (!locked && !lock_fail));
  // R9
  lock_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ld_s));

endmodule

// File: rtl/synth_seq.sv
module synth_seq
  import synth_prog_pkg::*;
#(
  parameter int unsigned NREG  = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             pwr_en,
  input  logic             req_valid,
  input  logic [SEL_W-1:0] req_sel,
  output logic             req_ready,
  input  logic             tx_busy,
  input  logic             tx_done,
  output logic             tx_start,
  output logic [SEL_W-1:0] word_sel,
  output logic             busy,
  output logic             poll_go
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NREG - 1);

  seq_st_t          st;
  logic [SEL_W-1:0] idx, sel_q;

  wire init_last = tx_done && (st == SQ_INIT) && (idx == '0);
  wire take      = req_valid && (st == SQ_IDLE) && (req_sel <= LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SQ_OFF; idx <= LAST; sel_q <= '0;
    end else if (!pwr_en) begin
      st <= SQ_OFF; idx <= LAST;
    end else begin
      case (st)
        SQ_OFF:  if (ce) begin st <= SQ_INIT; idx <= LAST; end
        SQ_INIT: if (tx_done) begin
          if (idx == '0) st <= SQ_IDLE;
          else idx <= idx - 1'b1;
        end
        SQ_IDLE: if (take) begin sel_q <= req_sel; st <= SQ_UPD; end
        default: if (tx_done) st <= SQ_IDLE;
      endcase
    end
  end

  assign tx_start  = pwr_en && !tx_busy && (st == SQ_INIT || st == SQ_UPD);
  assign word_sel  = (st == SQ_INIT) ? idx : sel_q;
  assign req_ready = (st == SQ_IDLE);
  assign busy      = (st != SQ_IDLE) || tx_busy;
  assign poll_go   = init_last;

  // R4
  init_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && st == SQ_INIT && idx != '0 && pwr_en) |=> (idx == $past(idx) - 1'b1));

endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl #(
  parameter int unsigned CLKDIV   = 2,
  parameter int unsigned NREG     = 6,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned SEL_W    = 3,
  parameter int unsigned POLL_W   = 8,
  parameter int unsigned LOCK_TMO = 2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_en,
  input  logic [NREG*WORD_W-1:0] cfg_words,
  input  logic                   req_valid,
  input  logic [SEL_W-1:0]       req_sel,
  output logic                   req_ready,
  output logic                   busy,
  output logic                   done,
  input  logic [POLL_W-1:0]      lock_polls,
  output logic                   locked,
  output logic                   lock_fail,
  output logic                   ser_clk,
  output logic                   ser_data,
  output logic                   ser_le,
  output logic                   chip_en,
  input  logic                   lock_det
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NREG - 1);
  localparam int unsigned SLOTS = 1 << SEL_W;

  logic              ce_q, tx_busy, tx_done, tx_start, poll_go;
  logic [SEL_W-1:0]  word_sel;
  logic [WORD_W-1:0] slot [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NREG) begin : g_used
      assign slot[g] = cfg_words[g*WORD_W +: WORD_W];
    end else begin : g_pad
      assign slot[g] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ce_q <= 1'b0;
    else        ce_q <= pwr_en;
  end
  assign chip_en = ce_q;

  synth_seq #(.NREG(NREG), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce(ce_q), .pwr_en(pwr_en),
    .req_valid(req_valid), .req_sel(req_sel), .req_ready(req_ready),
    .tx_busy(tx_busy), .tx_done(tx_done), .tx_start(tx_start),
    .word_sel(word_sel), .busy(busy), .poll_go(poll_go)
  );

  synth_frame_tx #(.CLKDIV(CLKDIV), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .abort(!pwr_en), .start(tx_start),
    .word(slot[word_sel]), .busy(tx_busy), .done(tx_done),
    .sclk(ser_clk), .sdata(ser_data), .le(ser_le)
  );

  synth_lock_mon #(.POLL_W(POLL_W), .LOCK_TMO(LOCK_TMO)) u_lock (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .go(poll_go),
    .lock_det(lock_det), .lock_polls(lock_polls),
    .locked(locked), .lock_fail(lock_fail)
  );

  assign done = tx_done;

  // R4
  ce_first_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ser_le) |-> chip_en);
  // R7
  done_commit_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $rose(ser_le));
  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sel <= LAST && pwr_en) |=> busy);
  // R6
  drop_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sel > LAST && pwr_en) |=> (req_ready && ser_le));

endmodule

// File: tb/synth_prog_ctrl_tb.sv
`timescale 1ns/1ps
module synth_prog_ctrl_tb;
  localparam int CLKDIV = 3, NREG = 6, WORD_W = 32, SEL_W = 3, POLL_W = 8, LOCK_TMO = 300;

  logic clk = 0, rst_n = 0, pwr_en = 1, req_valid = 0, lock_det = 0;
  logic [SEL_W-1:0] req_sel = '0;
  logic [POLL_W-1:0] lock_polls = 8'd3;
  logic [NREG*WORD_W-1:0] cfg_words;
  logic req_ready, busy, done, locked, lock_fail, ser_clk, ser_data, ser_le, chip_en;

  always #2.5 clk = ~clk;

  synth_prog_ctrl #(.CLKDIV(CLKDIV), .NREG(NREG), .WORD_W(WORD_W), .SEL_W(SEL_W),
    .POLL_W(POLL_W), .LOCK_TMO(LOCK_TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .cfg_words(cfg_words),
    .req_valid(req_valid), .req_sel(req_sel), .req_ready(req_ready), .busy(busy),
    .done(done), .lock_polls(lock_polls), .locked(locked), .lock_fail(lock_fail),
    .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le), .chip_en(chip_en),
    .lock_det(lock_det));

  int checks = 0, fails = 0, frames = 0, wd = 0;
  bit mon_on = 0;

  function automatic logic [31:0] slot_val(input int k);
    return (32'hC3A5_0F00 ^ (32'h0101_1F2B * (k + 1))) + 32'(k);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // behavioural reference state
  logic [31:0] exp_q[$];
  logic [31:0] bits;
  int nbits = 0, seg = 0, sess_done = 0, m_run = 0, m_tmo = 0;
  bit p_le = 1, p_sclk = 0, p_data = 0, p_ce = 0, first_frame = 0, go_prev = 0;
  bit h1 = 0, h2 = 0, m_poll = 0, m_locked = 0, m_fail = 0;

  always @(negedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
    if (mon_on) begin
      // R8 chip enable follows power enable by one cycle
      chk(chip_en === pwr_en, "R8 chip_en", chip_en, pwr_en);
      if (chip_en && !p_ce) begin
        for (int k = NREG - 1; k >= 0; k--) exp_q.push_back(slot_val(k));
        first_frame = 1; sess_done = 0;
      end
      if (!chip_en) begin exp_q.delete(); nbits = 0; sess_done = 0; end
      // R2
      if (ser_le) chk(!ser_clk, "R2 clk low under le", ser_clk, 0);
      if (ser_clk && p_sclk) chk(ser_data == p_data, "R2 data stable", ser_data, p_data);
      // R3 phase lengths and gap
      if (ser_le != p_le || ser_clk != p_sclk) begin
        if (chip_en && !p_le) chk(seg == CLKDIV, "R3 phase length", seg, CLKDIV);
        if (p_le && !ser_le && !first_frame) chk(seg >= 4*CLKDIV, "R3 le gap", seg, 4*CLKDIV);
        if (!ser_le) first_frame = 0;
        seg = 1;
      end else seg++;
      // R1 capture
      if (!ser_le && p_le) begin
        nbits = 0; bits = '0;
        chk(chip_en, "R4 ce before le", chip_en, 1);
      end
      if (chip_en && !ser_le && ser_clk && !p_sclk) begin bits = {bits[30:0], ser_data}; nbits++; end
      if (chip_en && ser_le && !p_le) begin
        frames++;
        chk(nbits == 32, "R1 bit count", nbits, 32);
        if (exp_q.size() == 0) chk(0, "R1 unexpected word", bits, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(bits == e, "R1 word value/order", bits, e);
        end
      end
      // R7
      chk(done === (chip_en && ser_le && !p_le), "R7 done pulse", done, chip_en && ser_le && !p_le);
      // R5
      if (!ser_le) chk(busy, "R5 busy in window", busy, 1);
      if (sess_done < NREG) chk(!req_ready, "R5 ready during init", req_ready, 0);
      // R9/R10 lock model
      if (!pwr_en) begin m_poll = 0; m_run = 0; m_tmo = 0; m_locked = 0; m_fail = 0; end
      else if (go_prev) begin m_poll = 1; m_run = 0; m_tmo = 0; m_locked = 0; m_fail = 0; end
      else if (m_poll) begin
        int need;
        need = (lock_polls == 0) ? 1 : int'(lock_polls);
        if (h2 && (m_run + 1 >= need)) begin m_locked = 1; m_poll = 0; end
        else begin
          m_run = h2 ? m_run + 1 : 0;
          if (m_tmo == LOCK_TMO - 1) begin m_fail = 1; m_poll = 0; end
          m_tmo++;
        end
      end
      chk(locked === m_locked, "R9 locked", locked, m_locked);
      chk(lock_fail === m_fail, "R10 lock_fail", lock_fail, m_fail);
      h2 = h1; h1 = lock_det;
      go_prev = 0;
      if (done && chip_en) begin
        sess_done++;
        if (sess_done == NREG) go_prev = 1;
      end
      p_le = ser_le; p_sclk = ser_clk; p_data = ser_data; p_ce = chip_en;
    end
  end

  task automatic send(input int s);
    while (!req_ready) @(negedge clk);
    #1; req_valid = 1; req_sel = SEL_W'(s);
    if (s < NREG) exp_q.push_back(slot_val(s));
    @(negedge clk); #1; req_valid = 0;
  endtask

  task automatic wait_idle();
    while (!(req_ready && !busy)) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) cfg_words[k*WORD_W +: WORD_W] = slot_val(k);
    repeat (3) @(negedge clk);
    // R4 reset state
    chk(ser_le && !ser_clk && !chip_en && !req_ready && !locked && !done,
        "R4 reset state", {ser_le, ser_clk, chip_en, req_ready, locked, done}, 6'b100000);
    #1; rst_n = 1; mon_on = 1;
    // power-up, lock with runs of four highs, threshold three
    for (int c = 0; c < 5000 && !locked; c++) begin
      @(negedge clk); #1; lock_det = (c % 5) != 0;
    end
    chk(locked, "R9 lock reached", locked, 1);
    chk(exp_q.size() == 0, "R4 six words sent", exp_q.size(), 0);
    // rewrites, back to back
    send(0); send(3); wait_idle();
    chk(exp_q.size() == 0, "R5 rewrites sent", exp_q.size(), 0);
    // dropped selector
    begin
      int f0;
      f0 = frames;
      send(7);
      chk(req_ready, "R6 ready after drop", req_ready, 1);
      repeat (30) @(negedge clk);
      chk(frames == f0 && ser_le, "R6 no window", frames, f0);
    end
    send(5); wait_idle();
    chk(exp_q.size() == 0, "R5 slot 5 sent", exp_q.size(), 0);
    chk(locked, "R10 locked holds", locked, 1);
    // power-down mid-window
    send(1);
    while (ser_le) @(negedge clk);
    repeat (40) @(negedge clk);
    #1; pwr_en = 0;
    @(negedge clk);
    chk(!chip_en && ser_le && !ser_clk && !locked, "R8 power-down",
        {chip_en, ser_le, ser_clk, locked}, 4'b0100);
    repeat (10) @(negedge clk);
    #1; lock_polls = '0; lock_det = 1; pwr_en = 1;
    for (int c = 0; c < 5000 && !locked; c++) @(negedge clk);
    chk(locked, "R9 lock with zero threshold", locked, 1);
    chk(exp_q.size() == 0, "R8 reinit complete", exp_q.size(), 0);
    // timeout
    #1; pwr_en = 0; lock_det = 0;
    repeat (5) @(negedge clk);
    #1; pwr_en = 1;
    for (int c = 0; c < 5000 && !lock_fail; c++) @(negedge clk);
    chk(lock_fail && !locked, "R10 timeout", {lock_fail, locked}, 2'b10);
    repeat (20) @(negedge clk);
    chk(lock_fail, "R10 fail holds", lock_fail, 1);
    summary();
  end
endmodule